// File: doc/BRIEF.md
# Strobed Pad Pull-Resistor Configuration Latch

This block holds the pull-resistor setting of every pad in a bank of general-purpose pins. The setting is not written per pin. Software first writes a 2-bit pull code into one shared control word. It then raises bits in a set of pin-strobe words. Each pin whose strobe bit changes from 0 to 1 copies the shared code into its own private pull state. That state drives the pad's pull-down and pull-up controls, and software cannot read it back.

The shared code must be stable for a settling window before any strobe edge. A countdown restarts on every control write. If a strobe bit rises while the countdown is still running, a sticky error flag is set. The flag can be read at a status offset just above the strobe words.

The register port is a simple one: one write per cycle, with writes taking effect at the clock edge, and a combinational read.

Top module: `pud_latch_top`

## Requirements
- R1: After a synchronous active-high reset, the control word, all strobe words and the status flag read 0, and every pin's pull output is 0 (off).
- R2: A write to offset 0x94 stores the low 2 bits of the data as the pull code. Reading 0x94 returns that code in bits [1:0] and zeros above it.
- R3: Pin p has its strobe bit at bit p%32 of the word at offset 0x98 + 4*(p/32). These words read back what was written. Bits that belong to no existing pin (pin index 54 or above) always read 0.
- R4: When a write makes pin p's strobe bit go from 0 to 1, pull_o[2p+1:2p] takes the current control code in the cycle after that write. The encoding is 0 = off, 1 = pull-down, 2 = pull-up.
- R5: While a strobe bit stays at 1, rewriting it as 1 after a control change leaves the pin's state unchanged. Clearing the strobe bit also leaves the state unchanged.
- R6: Several pins strobed by the same write, in one word, all capture the same code. Pins whose strobe bit does not rise keep their state.
- R7: Control code 3 is reserved. A pin that captures it goes to 0 (off).
- R8: A strobe rise in the write made 1 to 150 cycles after the most recent control write sets status bit 0 at offset 0xA0. A rise 151 or more cycles after that write does not set it. Every control write restarts the window, and once set the flag stays at 1 until reset.
- R9: Reads of offsets that hold no register return 0, so the per-pin pull state cannot be read through the register port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| pull_o | output | 108 | Per-pin 2-bit pull state, pin p at [2p+1:2p] |

## Verification
The capture path is exercised in four ways:
- a single pin strobed alone;
- two pins in the upper word strobed together, with a nonexistent bit set in the same write;
- a strobe bit held high across a control change;
- a capture of the reserved code.

Together these separate edge capture from level capture and single-bit capture from word-wide capture. They also separate folding of code 3 from passing it through. The settling window is probed exactly at 150 and at 151 cycles, and once with a second control write partway through the window. This shows whether the window is counted from the latest write and whether its edge is off by one. A behavioural reference model is compared with every pin's output on each clock.

// File: rtl/pud_latch_pkg.sv
package pud_latch_pkg;

    typedef enum logic [1:0] {
        PULL_OFF  = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_UP   = 2'd2,
        PULL_RSVD = 2'd3
    } pull_code_t;

    localparam int CTRL_OFS = 'h94;
    localparam int STRB_OFS = 'h98;

    // Reserved code is stored as off so pads never see an undefined setting.
    function automatic pull_code_t fold_code(input pull_code_t c);
        return (c == PULL_RSVD) ? PULL_OFF : c;
    endfunction

    function automatic int strobe_word_ofs(input int bank);
        return STRB_OFS + 4 * bank;
    endfunction

endpackage

// File: rtl/pud_ctrl_regs.sv
module pud_ctrl_regs
    import pud_latch_pkg::*;
#(
    parameter int NUM_PINS     = 54,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 8,
    parameter int SETUP_CYCLES = 150
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output pull_code_t          code_o,
    output logic [NUM_PINS-1:0] rise_o
);
    localparam int BANKS    = (NUM_PINS + DATA_W - 1) / DATA_W;
    localparam int STRB_W   = BANKS * DATA_W;
    localparam int CNT_W    = $clog2(SETUP_CYCLES + 1);
    localparam int STAT_OFS = STRB_OFS + 4 * BANKS;

    pull_code_t          ctrl_q;
    logic [STRB_W-1:0]   strb_q, strb_nx;
    logic [CNT_W-1:0]    cnt_q;
    logic                err_q;
    logic                ctrl_wr;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_OFS));

    always_comb begin
        strb_nx = strb_q;
        for (int b = 0; b < BANKS; b++) begin
            if (wr_en && (wr_addr == ADDR_W'(strobe_word_ofs(b))))
                strb_nx[b*DATA_W +: DATA_W] = wr_data;
        end
        for (int i = NUM_PINS; i < STRB_W; i++) strb_nx[i] = 1'b0;
    end

    assign rise_o = strb_nx[NUM_PINS-1:0] & ~strb_q[NUM_PINS-1:0];
    assign code_o = ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= PULL_OFF;
            strb_q <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            strb_q <= strb_nx;
            if (ctrl_wr) begin
                ctrl_q <= pull_code_t'(wr_data[1:0]);
                cnt_q  <= CNT_W'(SETUP_CYCLES);
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if ((|rise_o) && (cnt_q != '0)) err_q <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_OFS)) rd_data = DATA_W'(ctrl_q);
        if (rd_addr == ADDR_W'(STAT_OFS)) rd_data = DATA_W'(err_q);
        for (int b = 0; b < BANKS; b++) begin
            if (rd_addr == ADDR_W'(strobe_word_ofs(b)))
                rd_data = strb_q[b*DATA_W +: DATA_W];
        end
    end

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    a_r8_early_rise_flags: assert property (@(posedge clk) disable iff (rst)
        ((|rise_o) && (cnt_q != '0)) |=> err_q);
    a_r8_window_restart: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (cnt_q == CNT_W'(SETUP_CYCLES)));
    a_r3_absent_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (strb_q >> NUM_PINS) == '0);

endmodule

// File: rtl/pud_pin_cell.sv
module pud_pin_cell
    import pud_latch_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe_i,
    input  pull_code_t code_i,
    output pull_code_t pull_o
);
    pull_code_t state_q;

    always_ff @(posedge clk) begin
        if (rst)           state_q <= PULL_OFF;
        else if (strobe_i) state_q <= fold_code(code_i);
    end

    assign pull_o = state_q;

    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> (state_q == fold_code($past(code_i))));
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !strobe_i |=> $stable(state_q));
    a_r7_never_reserved: assert property (@(posedge clk) disable iff (rst)
        state_q != PULL_RSVD);

endmodule

// File: rtl/pud_latch_top.sv
module pud_latch_top
    import pud_latch_pkg::*;
#(
    parameter int NUM_PINS     = 54,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 8,
    parameter int SETUP_CYCLES = 150
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic [2*NUM_PINS-1:0] pull_o
);
    pull_code_t          code;
    logic [NUM_PINS-1:0] rise;

    pud_ctrl_regs #(
        .NUM_PINS    (NUM_PINS),
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .SETUP_CYCLES(SETUP_CYCLES)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .code_o (code),
        .rise_o (rise)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pull_code_t pin_pull;
        pud_pin_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .strobe_i(rise[p]),
            .code_i  (code),
            .pull_o  (pin_pull)
        );
        assign pull_o[2*p +: 2] = pin_pull;
    end

endmodule

// File: tb/tb_pud_latch_top.sv
module tb_pud_latch_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN  = 54;
    localparam int SETUP = 150;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [7:0]   rd_addr = '0;
    logic [31:0]  rd_data;
    logic [107:0] pull_o;

    pud_latch_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .pull_o(pull_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state
    int       ctrl_m;
    bit [63:0] strb_m;
    int       pull_m [NPIN];
    int       cnt_m;
    bit       err_m;

    function automatic int fold(input int c);
        return (c == 3) ? 0 : c;
    endfunction

    task automatic model_edge();
        bit [63:0] nx;
        bit        any_rise;
        nx = strb_m;
        any_rise = 1'b0;
        if (rst) begin
            ctrl_m = 0; strb_m = '0; cnt_m = 0; err_m = 1'b0;
            for (int p = 0; p < NPIN; p++) pull_m[p] = 0;
            return;
        end
        if (wr_en && wr_addr == 8'h98) nx[31:0]  = wr_data;
        if (wr_en && wr_addr == 8'h9C) nx[63:32] = wr_data;
        nx[63:NPIN] = '0;
        for (int p = 0; p < NPIN; p++) begin
            if (nx[p] && !strb_m[p]) begin
                pull_m[p] = fold(ctrl_m);
                any_rise = 1'b1;
            end
        end
        if (any_rise && cnt_m != 0) err_m = 1'b1;
        if (wr_en && wr_addr == 8'h94) begin
            ctrl_m = int'(wr_data[1:0]);
            cnt_m = SETUP;
        end else if (cnt_m > 0) begin
            cnt_m = cnt_m - 1;
        end
        strb_m = nx;
    endtask

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_pins();
        logic [107:0] exp;
        for (int p = 0; p < NPIN; p++) exp[2*p +: 2] = 2'(pull_m[p]);
        check(pull_o === exp, "R4 per-cycle pull state", 128'(pull_o), 128'(exp));
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_pins();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #1;
        check(rd_data === exp, req, 128'(rd_data), 128'(exp));
    endtask

    task automatic pin_check(input int p, input int exp, input string req);
        check(pull_o[2*p +: 2] === 2'(exp), req, 128'(pull_o[2*p +: 2]), 128'(exp));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        rd_check(8'h94, 32'h0, "R1 control after reset");
        rd_check(8'h98, 32'h0, "R1 strobe word 0 after reset");
        rd_check(8'h9C, 32'h0, "R1 strobe word 1 after reset");
        rd_check(8'hA0, 32'h0, "R1 status after reset");
        check(pull_o === '0, "R1 pulls off after reset", 128'(pull_o), 128'h0);

        // R2 only low two bits kept
        wr(8'h94, 32'hFFFF_FFF6);
        rd_check(8'h94, 32'h2, "R2 control keeps low bits");
        idle(SETUP);
        // R4 single pin capture of pull-up
        wr(8'h98, 32'h0000_0020);
        pin_check(5, 2, "R4 pin5 captures pull-up");
        pin_check(4, 0, "R6 neighbour pin4 untouched");
        rd_check(8'hA0, 32'h0, "R8 rise after 151 cycles leaves flag clear");
        rd_check(8'h98, 32'h0000_0020, "R3 strobe word 0 readback");
        wr(8'h98, 32'h0);

        // R3/R6 multi-pin capture in upper word with absent bit
        wr(8'h94, 32'h1);
        idle(SETUP);
        wr(8'h9C, 32'h8020_0001);
        pin_check(32, 1, "R6 pin32 captures pull-down");
        pin_check(53, 1, "R6 pin53 captures pull-down");
        pin_check(5, 2, "R6 pin5 keeps pull-up");
        rd_check(8'h9C, 32'h0020_0001, "R3 absent pin bits read 0");

        // R5 held strobe ignores later code
        wr(8'h94, 32'h2);
        idle(SETUP);
        wr(8'h9C, 32'h0020_0001);
        pin_check(32, 1, "R5 held strobe does not recapture");
        wr(8'h9C, 32'h0);
        pin_check(53, 1, "R5 clearing strobe keeps state");

        // R7 reserved code folds to off
        wr(8'h98, 32'h0);
        wr(8'h94, 32'h3);
        idle(SETUP);
        wr(8'h98, 32'h0000_0020);
        pin_check(5, 0, "R7 reserved code captured as off");
        rd_check(8'h94, 32'h3, "R2 reserved code readable in control");
        wr(8'h98, 32'h0);

        // R9 unmapped offsets read 0
        rd_check(8'h00, 32'h0, "R9 unmapped offset 0x00");
        rd_check(8'hA4, 32'h0, "R9 unmapped offset 0xA4");

        // R8 boundary: rise exactly 150 cycles after control write
        wr(8'h94, 32'h1);
        idle(SETUP - 1);
        wr(8'h98, 32'h0000_0080);
        rd_check(8'hA0, 32'h1, "R8 rise at 150 cycles sets flag");
        pin_check(7, 1, "R4 early capture still loads code");
        idle(20);
        rd_check(8'hA0, 32'h1, "R8 flag sticky");

        // R8 window restarts on each control write
        do_reset();
        wr(8'h94, 32'h2);
        idle(99);
        wr(8'h94, 32'h2);
        idle(99);
        wr(8'h98, 32'h0000_0001);
        rd_check(8'hA0, 32'h1, "R8 second control write restarts window");

        // R8 boundary: rise exactly 151 cycles after control write
        do_reset();
        wr(8'h94, 32'h1);
        idle(SETUP);
        wr(8'h9C, 32'h0000_0002);
        rd_check(8'hA0, 32'h0, "R8 rise at 151 cycles no flag");
        pin_check(33, 1, "R4 pin33 captures pull-down");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule